// File: doc/BRIEF.md
# Two-Channel Pixel Merger with Per-Line Black Clamp

This block sits right after the converters of a frame-transfer imager. The imager reads each line out through two serial channels. One channel carries the odd-numbered columns and the other carries the even-numbered columns. The channels are strobed half a pixel apart, so in the block's clock domain their valid strobes fall on alternating cycles. The block registers both channels and drops the padding samples that lead each channel's readout. It then interleaves the remaining samples into one raster-ordered stream at twice the per-channel rate.

The left edge of every line carries light-shielded reference columns. The block adds up those reference samples, divides by their count to get a per-line black level, and subtracts it from every active pixel of the same line, clamping at zero. Reference samples pass through unchanged. Each output pixel carries flags: an active flag, a start-of-line pulse, and a start-of-frame pulse. The active flag is low for reference columns, for the shielded rows at the bottom of the frame, and for any line beyond the frame length.

Top module: `ccd_pixel_merge`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `pixValid`, `pixActive`, `lineFirst` and `frameFirst` are low; a reset in mid-line discards the partial line.
- R2: After each `lineStart`, the first DUMMY_N valid samples of each channel produce no output.
- R3: Each accepted sample yields exactly one output pixel two clock edges after its input strobe is captured. Odd-channel samples fill positions 0, 2, 4, … and even-channel samples fill positions 1, 3, 5, … of the line.
- R4: The first DARK_COLS positions of a line are output with their raw value and with `pixActive` low.
- R5: The black level is floor(sum of the line's DARK_COLS reference samples / DARK_COLS). Each later position of that line outputs max(sample − black, 0).
- R6: `pixActive` is high for positions at or beyond DARK_COLS on lines 0 … LINES−DARK_LINES−1 of a frame. It is low on the last DARK_LINES lines and on any line past LINES−1.
- R7: `lineFirst` is high only with position 0 of a line. `frameFirst` is high only with position 0 of the line whose `lineStart` came with `frameStart`.
- R8: Once DUMMY_N + (DARK_COLS+ACTIVE_COLS)/2 samples of a channel have been seen on a line, further samples of that channel are ignored until the next `lineStart`. A line therefore never yields more than DARK_COLS+ACTIVE_COLS pixels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at the merged pixel rate |
| rst | input | 1 | Synchronous active-high reset |
| oddData | input | SAMPLE_W | Sample of the odd-column channel |
| oddValid | input | 1 | Strobe for `oddData` |
| evenData | input | SAMPLE_W | Sample of the even-column channel |
| evenValid | input | 1 | Strobe for `evenData`, never in the same cycle as `oddValid` |
| lineStart | input | 1 | One-cycle pulse before a line's samples |
| frameStart | input | 1 | Qualifies `lineStart` as the first line of a frame |
| pixData | output | SAMPLE_W | Merged, black-corrected pixel |
| pixValid | output | 1 | `pixData` holds a pixel |
| pixActive | output | 1 | Pixel belongs to the active image |
| lineFirst | output | 1 | Pixel is position 0 of its line |
| frameFirst | output | 1 | Pixel is position 0 of line 0 |

## Verification
A wrong skip count in a channel counter shows up at position 0 of the very next line. Either a padding value appears there, or the odd/even order shifts and every later pixel of that line mismatches. A wrong black level first shows on the first active position, DARK_COLS pixels after `lineFirst`. A line-counter error only shows in the active flag of the bottom rows, so the bench walks a full short frame and one line past it. The bench also uses reference values above the active data to force the zero clamp.

// File: rtl/ccd_merge_pkg.sv
package ccd_merge_pkg;

  // Per-cycle strobes from the control to the datapath
  typedef struct packed {
    logic take;        // a sample is accepted this cycle
    logic selEven;     // accepted sample is from the even channel
    logic isDark;      // position lies in the reference columns
    logic lastDark;    // last reference position: latch black level
    logic clearAcc;    // new line: restart the reference sum
    logic active;      // position belongs to the active image
    logic lineFirst;   // position 0 of a line
    logic frameFirst;  // position 0 of line 0
  } strobe_t;

endpackage

// File: rtl/ccd_merge_ctrl.sv
module ccd_merge_ctrl
  import ccd_merge_pkg::*;
#(
  parameter int DUMMY_N     = 12,
  parameter int DARK_COLS   = 24,
  parameter int ACTIVE_COLS = 1000,
  parameter int LINES       = 512,
  parameter int DARK_LINES  = 2
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    oddValid,
  input  logic    evenValid,
  input  logic    lineStart,
  input  logic    frameStart,
  output strobe_t strobe
);

  localparam int COLS     = DARK_COLS + ACTIVE_COLS;
  localparam int HALF     = COLS / 2;
  localparam int CH_LIMIT = DUMMY_N + HALF;
  localparam int CW       = $clog2(CH_LIMIT + 1);
  localparam int COLW     = $clog2(COLS + 1);
  localparam int LW       = $clog2(LINES + 1);
  localparam int ACT_LINES = LINES - DARK_LINES;

  logic [1:0] chValid;
  logic [1:0] chIn;

  assign chValid = {evenValid, oddValid};

  // One sample counter per channel: skip padding, then cap at the line length
  for (genvar ch = 0; ch < 2; ch++) begin : g_chan
    logic [CW-1:0] cnt;
    logic [CW-1:0] base;

    always_comb begin
      base     = lineStart ? '0 : cnt;
      chIn[ch] = chValid[ch] && (base >= CW'(DUMMY_N)) && (base < CW'(CH_LIMIT));
    end

    always_ff @(posedge clk) begin
      if (rst)                                         cnt <= '0;
      else if (chValid[ch] && (base < CW'(CH_LIMIT)))   cnt <= base + 1'b1;
      else                                             cnt <= base;
    end
  end

  logic [COLW-1:0] col, colBase;
  logic [LW-1:0]   line, lineCur;
  logic            take;

  always_comb begin
    take    = |chIn;
    colBase = lineStart ? '0 : col;
    if (!lineStart)      lineCur = line;
    else if (frameStart) lineCur = '0;
    else if (line == LW'(LINES)) lineCur = line;   // beyond the frame: hold
    else                 lineCur = line + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      col  <= '0;
      line <= LW'(LINES);                           // no frame seen yet
    end else begin
      col  <= take ? colBase + 1'b1 : colBase;
      line <= lineCur;
    end
  end

  always_comb begin
    strobe            = '0;
    strobe.take       = take;
    strobe.selEven    = chIn[1];
    strobe.isDark     = colBase < COLW'(DARK_COLS);
    strobe.lastDark   = take && (colBase == COLW'(DARK_COLS - 1));
    strobe.clearAcc   = lineStart;
    strobe.active     = (colBase >= COLW'(DARK_COLS)) && (lineCur < LW'(ACT_LINES));
    strobe.lineFirst  = take && (colBase == '0);
    strobe.frameFirst = take && (colBase == '0) && (lineCur == '0);
  end

endmodule

// File: rtl/ccd_merge_dp.sv
module ccd_merge_dp
  import ccd_merge_pkg::*;
#(
  parameter int SAMPLE_W  = 12,
  parameter int DARK_COLS = 24
) (
  input  logic                clk,
  input  logic                rst,
  input  strobe_t             strobe,
  input  logic [SAMPLE_W-1:0] oddData,
  input  logic [SAMPLE_W-1:0] evenData,
  output logic [SAMPLE_W-1:0] pixData,
  output logic                pixValid,
  output logic                pixActive,
  output logic                lineFirst,
  output logic                frameFirst
);

  localparam int AW = SAMPLE_W + $clog2(DARK_COLS + 1);

  logic [SAMPLE_W-1:0] sample, black, corrected;
  logic [AW-1:0]       acc, accBase, accNext;

  always_comb begin
    sample    = strobe.selEven ? evenData : oddData;
    accBase   = strobe.clearAcc ? '0 : acc;
    accNext   = (strobe.take && strobe.isDark) ? accBase + AW'(sample) : accBase;
    corrected = (sample > black) ? sample - black : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc        <= '0;
      black      <= '0;
      pixData    <= '0;
      pixValid   <= 1'b0;
      pixActive  <= 1'b0;
      lineFirst  <= 1'b0;
      frameFirst <= 1'b0;
    end else begin
      acc <= accNext;
      if (strobe.lastDark) black <= SAMPLE_W'(accNext / AW'(DARK_COLS));
      pixData    <= strobe.isDark ? sample : corrected;
      pixValid   <= strobe.take;
      pixActive  <= strobe.take && strobe.active;
      lineFirst  <= strobe.lineFirst;
      frameFirst <= strobe.frameFirst;
    end
  end

endmodule

// File: rtl/ccd_pixel_merge.sv
module ccd_pixel_merge
  import ccd_merge_pkg::*;
#(
  parameter int SAMPLE_W    = 12,
  parameter int DUMMY_N     = 12,
  parameter int DARK_COLS   = 24,
  parameter int ACTIVE_COLS = 1000,
  parameter int LINES       = 512,
  parameter int DARK_LINES  = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [SAMPLE_W-1:0] oddData,
  input  logic                oddValid,
  input  logic [SAMPLE_W-1:0] evenData,
  input  logic                evenValid,
  input  logic                lineStart,
  input  logic                frameStart,
  output logic [SAMPLE_W-1:0] pixData,
  output logic                pixValid,
  output logic                pixActive,
  output logic                lineFirst,
  output logic                frameFirst
);

  logic [SAMPLE_W-1:0] rOddData, rEvenData;
  logic                rOddValid, rEvenValid, rLineStart, rFrameStart;
  strobe_t             strobe;

  // Input capture stage
  always_ff @(posedge clk) begin
    if (rst) begin
      rOddData    <= '0;
      rEvenData   <= '0;
      rOddValid   <= 1'b0;
      rEvenValid  <= 1'b0;
      rLineStart  <= 1'b0;
      rFrameStart <= 1'b0;
    end else begin
      rOddData    <= oddData;
      rEvenData   <= evenData;
      rOddValid   <= oddValid;
      rEvenValid  <= evenValid;
      rLineStart  <= lineStart;
      rFrameStart <= frameStart;
    end
  end

  ccd_merge_ctrl #(
    .DUMMY_N(DUMMY_N), .DARK_COLS(DARK_COLS), .ACTIVE_COLS(ACTIVE_COLS),
    .LINES(LINES), .DARK_LINES(DARK_LINES)
  ) ctrl (
    .clk(clk), .rst(rst),
    .oddValid(rOddValid), .evenValid(rEvenValid),
    .lineStart(rLineStart), .frameStart(rFrameStart),
    .strobe(strobe)
  );

  ccd_merge_dp #(.SAMPLE_W(SAMPLE_W), .DARK_COLS(DARK_COLS)) dp (
    .clk(clk), .rst(rst), .strobe(strobe),
    .oddData(rOddData), .evenData(rEvenData),
    .pixData(pixData), .pixValid(pixValid), .pixActive(pixActive),
    .lineFirst(lineFirst), .frameFirst(frameFirst)
  );

endmodule

// File: rtl/ccd_pixel_merge_chk.sv
module ccd_pixel_merge_chk #(
  parameter int DUMMY_N = 12,
  parameter int COLS    = 1024
) (
  input logic clk,
  input logic rst,
  input logic oddValid,
  input logic evenValid,
  input logic lineStart,
  input logic pixValid,
  input logic pixActive,
  input logic lineFirst
);

  logic [15:0] outCnt;   // pixels seen since the last lineFirst, inclusive

  always_ff @(posedge clk) begin
    if (rst)             outCnt <= '0;
    else if (lineFirst)  outCnt <= 16'd1;
    else if (pixValid && outCnt != 16'hFFFF) outCnt <= outCnt + 16'd1;
  end

  // R3
  no_dual_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    !(oddValid && evenValid));

  // R3
  out_latency_chk: assert property (@(posedge clk) disable iff (rst)
    pixValid |-> ($past(oddValid, 2) || $past(evenValid, 2)));

  // R4
  dark_first_chk: assert property (@(posedge clk) disable iff (rst)
    lineFirst |-> !pixActive);

  // R8
  out_count_chk: assert property (@(posedge clk) disable iff (rst)
    (pixValid && !lineFirst) |-> (outCnt < 16'(COLS)));

  if (DUMMY_N > 0) begin : g_skip
    // R2
    dummy_skip_chk: assert property (@(posedge clk) disable iff (rst)
      lineFirst |-> !$past(lineStart, 2));
  end

endmodule

bind ccd_pixel_merge ccd_pixel_merge_chk #(
  .DUMMY_N(DUMMY_N), .COLS(DARK_COLS + ACTIVE_COLS)
) chk (
  .clk(clk), .rst(rst), .oddValid(oddValid), .evenValid(evenValid),
  .lineStart(lineStart), .pixValid(pixValid), .pixActive(pixActive),
  .lineFirst(lineFirst)
);

// File: tb/ccd_pixel_merge_test.sv
`timescale 1ns/1ps
module ccd_pixel_merge_test;

  localparam int SW = 12, DN = 2, DC = 4, AC = 8, NL = 4, DL = 1;
  localparam int COLS = DC + AC, HALF = COLS / 2, PAD = 4095;

  logic clk = 1'b0, rst = 1'b1;
  logic [SW-1:0] oddData = '0, evenData = '0, pixData;
  logic oddValid = 0, evenValid = 0, lineStart = 0, frameStart = 0;
  logic pixValid, pixActive, lineFirst, frameFirst;

  always #4 clk = ~clk;   // 125 MHz

  ccd_pixel_merge #(.SAMPLE_W(SW), .DUMMY_N(DN), .DARK_COLS(DC),
    .ACTIVE_COLS(AC), .LINES(NL), .DARK_LINES(DL)) uut (
    .clk(clk), .rst(rst), .oddData(oddData), .oddValid(oddValid),
    .evenData(evenData), .evenValid(evenValid), .lineStart(lineStart),
    .frameStart(frameStart), .pixData(pixData), .pixValid(pixValid),
    .pixActive(pixActive), .lineFirst(lineFirst), .frameFirst(frameFirst));

  int compared = 0, mismatched = 0, cyc = 0, gotN = 0;
  bit done = 0;
  int gotData[0:127];
  bit gotAct[0:127], gotLf[0:127], gotFf[0:127];
  int gotCyc[0:127];

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (pixValid && gotN < 128) begin
      gotData[gotN] = int'(pixData);
      gotAct[gotN]  = pixActive;
      gotLf[gotN]   = lineFirst;
      gotFf[gotN]   = frameFirst;
      gotCyc[gotN]  = cyc;
      gotN++;
    end
  end

  // Lines: {frameStart, reference base, active base}
  localparam int VEC[6][3] = '{
    '{1, 100, 300}, '{0, 50, 40}, '{0, 3000, 200},
    '{0, 10, 500},  '{0, 20, 90}, '{1, 7, 60}};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int colVal(input int c, input int dBase, input int aBase);
    if (c < DC) return dBase + ((c == 1) ? 3 : (c == 2) ? 5 : (c == 3) ? 2 : 0);
    if (c == DC + 1) return 1;
    return aBase + 7 * c;
  endfunction

  task automatic sendLine(input bit fs, input int dBase, input int aBase, output int firstCyc);
    @(negedge clk); lineStart = 1; frameStart = fs;
    @(negedge clk); lineStart = 0; frameStart = 0;
    for (int k = 0; k <= DN + HALF; k++) begin
      bit real_ = (k >= DN) && (k < DN + HALF);
      oddValid = 1;
      oddData  = SW'(real_ ? colVal(2 * (k - DN), dBase, aBase) : PAD);
      if (k == DN) firstCyc = cyc;
      @(negedge clk); oddValid = 0; evenValid = 1;
      evenData = SW'(real_ ? colVal(2 * (k - DN) + 1, dBase, aBase) : PAD);
      @(negedge clk); evenValid = 0;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic checkLine(input int start, input int firstCyc, input int ln,
                           input int dBase, input int aBase);
    int black = (4 * dBase + 10) / DC;
    // R8: extra samples past the line length give no pixel
    check(gotN - start == COLS, "R8 pixel count", gotN - start, COLS);
    // R3: two-edge latency from the first accepted sample
    check(gotCyc[start] - firstCyc == 2, "R3 latency", gotCyc[start] - firstCyc, 2);
    for (int c = 0; c < COLS; c++) begin
      int v = colVal(c, dBase, aBase);
      int e = (c < DC) ? v : ((v > black) ? v - black : 0);
      bit ea = (c >= DC) && (ln < NL - DL);
      check(gotData[start + c] == e, (c == 0) ? "R2 pos0 data" : (c < DC) ? "R4 ref data" : "R5 corrected data",
            gotData[start + c], e);
      check(gotAct[start + c] == ea, (ln >= NL - DL) ? "R6 active flag" : "R4 R6 active flag",
            int'(gotAct[start + c]), int'(ea));
      check(gotLf[start + c] == (c == 0), "R7 lineFirst", int'(gotLf[start + c]), int'(c == 0));
      check(gotFf[start + c] == (c == 0 && ln == 0), "R7 frameFirst",
            int'(gotFf[start + c]), int'(c == 0 && ln == 0));
    end
  endtask

  initial begin
    int ln, start, fc;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!pixValid && !pixActive && !lineFirst && !frameFirst, "R1 reset outputs",
          int'({pixValid, pixActive, lineFirst, frameFirst}), 0);
    rst = 0;
    @(negedge clk);
    check(!pixValid, "R1 after release", int'(pixValid), 0);

    ln = 0;
    for (int i = 0; i < 6; i++) begin
      ln = VEC[i][0] ? 0 : ((ln >= NL) ? NL : ln + 1);
      start = gotN;
      sendLine(VEC[i][0] != 0, VEC[i][1], VEC[i][2], fc);
      checkLine(start, fc, ln, VEC[i][1], VEC[i][2]);
    end

    // R1: reset in mid-line discards the partial line
    @(negedge clk); lineStart = 1; frameStart = 1;
    @(negedge clk); lineStart = 0; frameStart = 0;
    for (int k = 0; k < DN + 3; k++) begin
      oddValid = 1; oddData = SW'(900 + k);
      @(negedge clk); oddValid = 0;
    end
    rst = 1;
    @(negedge clk);
    check(!pixValid, "R1 mid-line reset", int'(pixValid), 0);
    rst = 0;
    @(negedge clk);
    start = gotN;
    check(!pixValid, "R1 idle after reset", int'(pixValid), 0);
    sendLine(1, 400, 600, fc);
    checkLine(start, fc, 0, 400, 600);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      mismatched++; compared++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule